// File: doc/BRIEF.md
# Supply Window Fault Detector

This block watches a stream of digitised supply-voltage codes and raises separate overvoltage and undervoltage flags. A sample counts as too high when its code is strictly above an upper limit, and as too low when it is strictly below a lower limit. Each of these two raw comparison bits goes to its own debounce stage. A debounce stage changes its output only after the raw bit has held a new level for long enough, so short spikes on a noisy rail produce no fault.

The surrounding logic supplies a valid strobe with each sample code, the two limits, and a debounce length for each path in clock cycles. A debounce length of zero passes the comparison straight through with one register of delay. An enable input clears both debounced flags. One instance serves one rail, and a chip places one instance per monitored supply.

Top module: `supply_window_detector`

## Requirements
- R1: When a valid sample is taken, `ovr_raw` is 1 from the next cycle if the sample code is strictly greater than `hi_limit`. A code equal to `hi_limit` gives 0.
- R2: When a valid sample is taken, `udr_raw` is 1 from the next cycle if the sample code is strictly less than `lo_limit`. A code equal to `lo_limit` gives 0. If the limits overlap, both raw bits can be 1 at once.
- R3: Between valid samples both raw bits hold their values. A change to either limit has no effect until the next valid sample.
- R4: With a debounce length of 0, each debounced flag equals its raw bit one cycle later.
- R5: With a debounce length L, a debounced flag takes the new raw level L+1 cycles after the raw bit changes. This applies to both the rising and the falling edge. A raw level that lasts L cycles or fewer never reaches the flag. One that lasts L+1 cycles does.
- R6: If the raw bit returns to the debounced level before the flag has switched, the count starts again from zero.
- R7: The debounce lengths are taken only when a valid sample is taken. A change to a length input between samples does not alter a count that is already running.
- R8: While `enable` is low, both debounced flags are 0 from the next cycle and the counts are cleared. The raw bits keep following the samples. After `enable` rises, a raw level that is already 1 needs the full L+1 cycles to set the flag.
- R9: While `rst` is high, all four outputs are 0 from the next clock edge.
- R10: The two paths use their own debounce lengths and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | When low, clears both debounced flags and their counts |
| smp_vld | input | 1 | Qualifies `smp_code` for one cycle |
| smp_code | input | SAMPLE_W | Unsigned supply sample code |
| hi_limit | input | SAMPLE_W | Overvoltage limit (fault when code > limit) |
| lo_limit | input | SAMPLE_W | Undervoltage limit (fault when code < limit) |
| ovr_len | input | LEN_W | Overvoltage debounce length in cycles |
| udr_len | input | LEN_W | Undervoltage debounce length in cycles |
| ovr_raw | output | 1 | Registered overvoltage comparison |
| udr_raw | output | 1 | Registered undervoltage comparison |
| ovr_flt | output | 1 | Debounced overvoltage fault |
| udr_flt | output | 1 | Debounced undervoltage fault |

## Verification
The assertions assume that reset is high from the first clock edge, and that `smp_vld` and the sample code are driven to known values in every cycle. They do not assume anything about how the two limits relate to each other, or about when the length inputs change. For that reason the stimulus changes limits and lengths between samples as well as with them, and it includes an overlapping window. All inputs change on the falling clock edge, which keeps every input stable at each sampling edge. The longest debounce length used in the tests is small, so each debounced edge can be placed on an exact cycle.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned SWD_PATHS = 2;

  typedef enum logic [0:0] {
    SWD_OVR = 1'b0,
    SWD_UDR = 1'b1
  } swd_path_e;
endpackage

// File: rtl/swd_window_cmp.sv
module swd_window_cmp
  import swd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic [SAMPLE_W-1:0]  smp_code,
  input  logic [SAMPLE_W-1:0]  hi_limit,
  input  logic [SAMPLE_W-1:0]  lo_limit,
  output logic [SWD_PATHS-1:0] raw
);
  logic [SWD_PATHS-1:0] raw_q;

  // Limits are sampled on the same edge as the code, so a limit change
  // becomes visible only with the next qualified sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
    end else if (smp_vld) begin
      raw_q[SWD_OVR] <= (smp_code > hi_limit);
      raw_q[SWD_UDR] <= (smp_code < lo_limit);
    end
  end

  assign raw = raw_q;

  // R3: raw comparison bits hold between samples
  a_r3_raw_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(raw_q));

  // R1: equality with the upper limit is not a fault
  a_r1_hi_equal: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (smp_code == hi_limit)) |=> !raw_q[SWD_OVR]);

  // R2: equality with the lower limit is not a fault
  a_r2_lo_equal: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (smp_code == lo_limit)) |=> !raw_q[SWD_UDR]);
endmodule

// File: rtl/swd_glitch_filter.sv
module swd_glitch_filter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_ld,
  input  logic [LEN_W-1:0] len_in,
  input  logic             raw_in,
  output logic             flt_out
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic             flt_q;

  // The length is captured with each qualified sample so that a new
  // value does not disturb a count already in progress.
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (cfg_ld) begin
      len_q <= len_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (raw_in == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= len_q) begin
      flt_q <= raw_in;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_out = flt_q;

  // R8: disable clears the debounced flag on the next cycle
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !flt_q);

  // R5: with the raw bit matching, the flag does not move
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (enable && (raw_in == flt_q)) |=> $stable(flt_q));

  // R5: any enabled change of the flag adopts the raw level
  a_r5_toward_raw: assert property (@(posedge clk) disable iff (rst)
    ((flt_q != $past(flt_q)) && $past(enable)) |-> (flt_q == $past(raw_in)));

  // R4: zero length tracks the raw bit one cycle later
  a_r4_zero_len: assert property (@(posedge clk) disable iff (rst)
    (enable && (len_q == '0)) |=> (flt_q == $past(raw_in)));
endmodule

// File: rtl/supply_window_detector.sv
module supply_window_detector
  import swd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_code,
  input  logic [SAMPLE_W-1:0] hi_limit,
  input  logic [SAMPLE_W-1:0] lo_limit,
  input  logic [LEN_W-1:0]    ovr_len,
  input  logic [LEN_W-1:0]    udr_len,
  output logic                ovr_raw,
  output logic                udr_raw,
  output logic                ovr_flt,
  output logic                udr_flt
);
  logic [SWD_PATHS-1:0] raw_bits;
  logic [SWD_PATHS-1:0] flt_bits;
  logic [LEN_W-1:0]     len_sel [SWD_PATHS];

  assign len_sel[SWD_OVR] = ovr_len;
  assign len_sel[SWD_UDR] = udr_len;

  swd_window_cmp #(
    .SAMPLE_W (SAMPLE_W)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_code (smp_code),
    .hi_limit (hi_limit),
    .lo_limit (lo_limit),
    .raw      (raw_bits)
  );

  for (genvar p = 0; p < SWD_PATHS; p++) begin : g_path
    swd_glitch_filter #(
      .LEN_W (LEN_W)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .enable  (enable),
      .cfg_ld  (smp_vld),
      .len_in  (len_sel[p]),
      .raw_in  (raw_bits[p]),
      .flt_out (flt_bits[p])
    );
  end

  assign ovr_raw = raw_bits[SWD_OVR];
  assign udr_raw = raw_bits[SWD_UDR];
  assign ovr_flt = flt_bits[SWD_OVR];
  assign udr_flt = flt_bits[SWD_UDR];

  // R9: reset clears every output
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !(ovr_raw || udr_raw || ovr_flt || udr_flt));
endmodule

// File: tb/sim_supply_window_detector.sv
`timescale 1ns/1ps
module sim_supply_window_detector;
  localparam int SW = 12;
  localparam int LW = 8;
  localparam int NV = 9;

  // {code, hi_limit, lo_limit, exp_ovr, exp_udr}
  localparam logic [3*SW+1:0] VEC [NV] = '{
    {12'd500,  12'd800,  12'd200, 1'b0, 1'b0},
    {12'd801,  12'd800,  12'd200, 1'b1, 1'b0},
    {12'd800,  12'd800,  12'd200, 1'b0, 1'b0},
    {12'd199,  12'd800,  12'd200, 1'b0, 1'b1},
    {12'd200,  12'd800,  12'd200, 1'b0, 1'b0},
    {12'd4095, 12'd4094, 12'd0,   1'b1, 1'b0},
    {12'd0,    12'd4095, 12'd1,   1'b0, 1'b1},
    {12'd0,    12'd4095, 12'd0,   1'b0, 1'b0},
    {12'd300,  12'd100,  12'd400, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst, enable, smp_vld;
  logic [SW-1:0] smp_code, hi_limit, lo_limit;
  logic [LW-1:0] ovr_len, udr_len;
  logic ovr_raw, udr_raw, ovr_flt, udr_flt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_window_detector #(.SAMPLE_W(SW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .smp_vld(smp_vld),
    .smp_code(smp_code), .hi_limit(hi_limit), .lo_limit(lo_limit),
    .ovr_len(ovr_len), .udr_len(udr_len),
    .ovr_raw(ovr_raw), .udr_raw(udr_raw), .ovr_flt(ovr_flt), .udr_flt(udr_flt)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [SW-1:0] code);
    smp_vld  = 1'b1;
    smp_code = code;
    @(negedge clk);
    smp_vld  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b0; smp_vld = 1'b0; smp_code = '0;
    hi_limit = '0; lo_limit = '0; ovr_len = '0; udr_len = '0;
    step(3);
    check("R9 ovr_raw", ovr_raw, 1'b0);
    check("R9 udr_raw", udr_raw, 1'b0);
    check("R9 ovr_flt", ovr_flt, 1'b0);
    check("R9 udr_flt", udr_flt, 1'b0);
    rst = 1'b0; enable = 1'b1;
    step(1);

    // R1 R2 R4: vector table, zero debounce length
    for (int i = 0; i < NV; i++) begin
      hi_limit = VEC[i][2*SW+1 -: SW];
      lo_limit = VEC[i][SW+1 -: SW];
      send(VEC[i][3*SW+1 -: SW]);
      check("R1 ovr_raw", ovr_raw, VEC[i][1]);
      check("R2 udr_raw", udr_raw, VEC[i][0]);
      step(1);
      check("R4 ovr_flt", ovr_flt, VEC[i][1]);
      check("R4 udr_flt", udr_flt, VEC[i][0]);
    end

    // R5: length 3 on the upper path, 1 on the lower path
    hi_limit = 12'd1000; lo_limit = 12'd100; ovr_len = 8'd3; udr_len = 8'd1;
    send(12'd500);
    step(3);
    send(12'd1500);
    step(3);
    check("R5 rise held early", ovr_flt, 1'b0);
    step(1);
    check("R5 rise after L+1", ovr_flt, 1'b1);
    send(12'd500);
    step(3);
    check("R5 fall held early", ovr_flt, 1'b1);
    step(1);
    check("R5 fall after L+1", ovr_flt, 1'b0);

    // R5: pulse of exactly L cycles is rejected
    send(12'd1500);
    step(2);
    send(12'd500);
    check("R5 L pulse rejected", ovr_flt, 1'b0);
    step(3);
    check("R5 L pulse rejected late", ovr_flt, 1'b0);

    // R5: pulse of L+1 cycles passes
    send(12'd1500);
    step(3);
    send(12'd500);
    check("R5 L+1 pulse passes", ovr_flt, 1'b1);
    step(4);
    check("R5 L+1 pulse released", ovr_flt, 1'b0);

    // R6: reversal restarts the count
    send(12'd1500);
    step(2);
    send(12'd500);
    send(12'd1500);
    step(3);
    check("R6 restart not yet", ovr_flt, 1'b0);
    step(1);
    check("R6 restart full count", ovr_flt, 1'b1);

    // R8: enable low clears flag, raw keeps value, full count on return
    enable = 1'b0;
    step(1);
    check("R8 flag cleared", ovr_flt, 1'b0);
    check("R8 raw kept", ovr_raw, 1'b1);
    enable = 1'b1;
    step(3);
    check("R8 recount early", ovr_flt, 1'b0);
    step(1);
    check("R8 recount done", ovr_flt, 1'b1);

    // R7: length captured with the sample; a later input change is ignored
    ovr_len = 8'd6;
    send(12'd500);
    ovr_len = 8'd0;
    step(4);
    check("R7 old length kept", ovr_flt, 1'b1);
    step(3);
    check("R7 captured length", ovr_flt, 1'b0);

    // R3: limit change without a sample leaves raw unchanged
    hi_limit = 12'd200;
    step(2);
    check("R3 limit not yet applied", ovr_raw, 1'b0);
    send(12'd500);
    check("R3 limit applied on sample", ovr_raw, 1'b1);
    step(1);
    check("R7 zero length now active", ovr_flt, 1'b1);

    // R10: lower path uses its own length 1 while upper path uses 0
    hi_limit = 12'd4000;
    send(12'd50);
    check("R10 udr_raw set", udr_raw, 1'b1);
    step(1);
    check("R10 udr_flt early", udr_flt, 1'b0);
    check("R10 ovr_flt released at length 0", ovr_flt, 1'b0);
    step(1);
    check("R10 udr_flt after 2", udr_flt, 1'b1);

    // R9: reset in mid operation
    rst = 1'b1;
    step(1);
    check("R9 udr_flt reset", udr_flt, 1'b0);
    check("R9 udr_raw reset", udr_raw, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule